// File: doc/BRIEF.md
# DMA Completion Interrupt Aggregator

This block gathers the one-cycle completion pulses from up to sixteen DMA channels into a sticky status vector. A per-bit mask gates each status bit, and the gated bits are OR-reduced into a single registered interrupt line for the processor. When a transfer finishes, the matching status bit is set. It stays set until software acknowledges that bit or wipes the whole vector.

Software reaches the block through a small word-addressed write strobe and a combinational read port. The mask can be loaded as a whole, or bits can be turned on or off one at a time through separate write-one aliases, so no read-modify-write is needed. Status can be cleared bit by bit through a write-one acknowledge, or all at once by any write to the wipe register. Two read-only views show the unmasked status and the masked status, and neither read changes any state. Register select codes: 0 mask (read/write), 1 mask-set, 2 mask-clear, 3 acknowledge, 4 wipe, 5 raw view, 6 masked view. Writes to codes 5 and 6 are ignored, and reads of codes 1 to 4 and 7 return 0.

Top module: `dma_done_irq_agg`

## Requirements
- R1: After reset every mask bit is 1 (all sources disabled), every status bit is 0 and irq is 0.
- R2: A 1 on done_pulse[i] at a clock edge sets status bit i after that edge, and the bit stays set with no further pulse until it is acknowledged or wiped.
- R3: A read with select 5 returns the status vector regardless of the mask, and repeated reads leave it unchanged.
- R4: A read with select 6 returns status AND NOT mask, and repeated reads leave state unchanged.
- R5: A write with select 0 loads the mask with the write data. A mask bit of 1 disables its source and a mask bit of 0 enables it. A read with select 0 returns the mask.
- R6: A write with select 1 sets each mask bit whose data bit is 1, and data bits of 0 leave the mask unchanged.
- R7: A write with select 2 clears each mask bit whose data bit is 1, and data bits of 0 leave the mask unchanged.
- R8: A write with select 3 clears each status bit whose data bit is 1, and data bits of 0 leave status unchanged.
- R9: A write with select 4 clears every status bit, whatever the data, including data of 0.
- R10: When a pulse on bit i arrives in the same cycle as an acknowledge or wipe covering bit i, bit i ends up set.
- R11: irq is registered: it equals the OR of (status AND NOT mask) as it stood one clock earlier.
- R12: Source i maps to bit i of every view and write field. Bits 0 to 11 are single sources and bits 15:12 form the four-channel converter group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_pulse | input | NUM_SRC | One-cycle completion pulse per source |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Register select code |
| reg_wdata | input | NUM_SRC | Write data, one bit per source |
| reg_rdata | output | NUM_SRC | Combinational read data for reg_addr |
| irq | output | 1 | Combined registered interrupt |

## Verification
The bench builds the block with NUM_SRC = 16 and ADDR_W = 3. This puts the converter group at bits 15:12 within reach, alongside the twelve single sources and every select code, including the unused one. A reference model inside the bench tracks mask, status and the lagging interrupt, so every read also checks irq one cycle behind the status change. Directed sequences cover the set-versus-clear collision on one bit, zero-data writes to each alias, and a wipe written with zero data.

// File: rtl/dma_irq_agg_pkg.sv
package dma_irq_agg_pkg;

  typedef enum logic [2:0] {
    SEL_MASK   = 3'd0,
    SEL_MSET   = 3'd1,
    SEL_MCLR   = 3'd2,
    SEL_ACK    = 3'd3,
    SEL_WIPE   = 3'd4,
    SEL_RAW    = 3'd5,
    SEL_MASKED = 3'd6,
    SEL_NONE   = 3'd7
  } reg_sel_e;

  // Next status bit: a fresh pulse beats any clear in the same cycle.
  function automatic logic status_bit_next(input logic cur, input logic pulse,
                                           input logic clr);
    return (cur & ~clr) | pulse;
  endfunction

  // Next mask bit: whole load, else set alias, else clear alias.
  function automatic logic mask_bit_next(input logic cur, input logic load,
                                         input logic set, input logic clr,
                                         input logic din);
    logic nxt;
    nxt = cur;
    if (load)      nxt = din;
    else if (set)  nxt = cur | din;
    else if (clr)  nxt = cur & ~din;
    return nxt;
  endfunction

  // A source contributes to the interrupt only when active and unmasked.
  function automatic logic gated_bit(input logic stat, input logic msk);
    return stat & ~msk;
  endfunction

endpackage

// File: rtl/dma_irq_agg_decode.sv
module dma_irq_agg_decode
  import dma_irq_agg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  output logic              stb_load,
  output logic              stb_mset,
  output logic              stb_mclr,
  output logic              stb_ack,
  output logic              stb_wipe
);

  reg_sel_e sel;

  always_comb begin
    sel      = reg_sel_e'(reg_addr[2:0]);
    stb_load = 1'b0;
    stb_mset = 1'b0;
    stb_mclr = 1'b0;
    stb_ack  = 1'b0;
    stb_wipe = 1'b0;
    if (reg_wr) begin
      unique case (sel)
        SEL_MASK: stb_load = 1'b1;
        SEL_MSET: stb_mset = 1'b1;
        SEL_MCLR: stb_mclr = 1'b1;
        SEL_ACK:  stb_ack  = 1'b1;
        SEL_WIPE: stb_wipe = 1'b1;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/dma_irq_agg_cell.sv
module dma_irq_agg_cell
  import dma_irq_agg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pulse,
  input  logic din,
  input  logic stb_load,
  input  logic stb_mset,
  input  logic stb_mclr,
  input  logic stb_ack,
  input  logic stb_wipe,
  output logic stat_q,
  output logic mask_q
);

  logic clr_hit;

  always_comb clr_hit = stb_wipe | (stb_ack & din);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
      mask_q <= 1'b1;
    end else begin
      stat_q <= status_bit_next(stat_q, pulse, clr_hit);
      mask_q <= mask_bit_next(mask_q, stb_load, stb_mset, stb_mclr, din);
    end
  end

endmodule

// File: rtl/dma_done_irq_agg.sv
module dma_done_irq_agg
  import dma_irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] done_pulse,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] reg_rdata,
  output logic               irq
);

  logic               stb_load, stb_mset, stb_mclr, stb_ack, stb_wipe;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] gated;
  logic               irq_next;
  reg_sel_e           rd_sel;

  dma_irq_agg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .stb_load (stb_load),
    .stb_mset (stb_mset),
    .stb_mclr (stb_mclr),
    .stb_ack  (stb_ack),
    .stb_wipe (stb_wipe)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    dma_irq_agg_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .pulse    (done_pulse[i]),
      .din      (reg_wdata[i]),
      .stb_load (stb_load),
      .stb_mset (stb_mset),
      .stb_mclr (stb_mclr),
      .stb_ack  (stb_ack),
      .stb_wipe (stb_wipe),
      .stat_q   (status_q[i]),
      .mask_q   (mask_q[i])
    );
    always_comb gated[i] = gated_bit(status_q[i], mask_q[i]);
  end

  always_comb irq_next = |gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_next;
  end

  always_comb begin
    rd_sel = reg_sel_e'(reg_addr[2:0]);
    unique case (rd_sel)
      SEL_MASK:   reg_rdata = mask_q;
      SEL_RAW:    reg_rdata = status_q;
      SEL_MASKED: reg_rdata = gated;
      default:    reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dma_done_irq_agg_chk.sv
module dma_done_irq_agg_chk #(
  parameter int NUM_SRC = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] done_pulse,
  input logic [NUM_SRC-1:0] reg_wdata,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               stb_mset,
  input logic               stb_mclr,
  input logic               stb_ack,
  input logic               stb_wipe,
  input logic               irq
);

  // R2
  pulse_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse != '0) |=> ((status_q & $past(done_pulse)) == $past(done_pulse)));

  // R9
  wipe_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_wipe && done_pulse == '0) |=> (status_q == '0));

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_ack && (reg_wdata & done_pulse) == '0) |=> ((status_q & $past(reg_wdata)) == '0));

  // R6
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_mset |=> ((mask_q & $past(reg_wdata)) == $past(reg_wdata)));

  // R7
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_mclr |=> ((mask_q & $past(reg_wdata)) == '0));

  // R2
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse == '0 && !stb_ack && !stb_wipe) |=> $stable(status_q));

  // R11
  irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ((status_q & ~mask_q) != '0)) |=> irq);

endmodule

bind dma_done_irq_agg dma_done_irq_agg_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .done_pulse (done_pulse),
  .reg_wdata  (reg_wdata),
  .status_q   (status_q),
  .mask_q     (mask_q),
  .stb_mset   (stb_mset),
  .stb_mclr   (stb_mclr),
  .stb_ack    (stb_ack),
  .stb_wipe   (stb_wipe),
  .irq        (irq)
);

// File: tb/dma_done_irq_agg_bench.sv
module dma_done_irq_agg_bench;
  localparam int NS = 16;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] done_pulse = '0;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [NS-1:0] reg_wdata = '0;
  logic [NS-1:0] reg_rdata;
  logic          irq;

  always #4 clk = ~clk; // 125 MHz

  dma_done_irq_agg #(.NUM_SRC(NS), .ADDR_W(AW)) u_dma_done_irq_agg (
    .clk(clk), .rst_n(rst_n), .done_pulse(done_pulse), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // Reference state built from the requirements.
  logic [NS-1:0] m_mask, m_stat;
  logic          m_irq;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask <= '1; m_stat <= '0; m_irq <= 1'b0;
    end else begin
      logic [NS-1:0] clr;
      clr = '0;
      if (reg_wr && reg_addr == 3'd3) clr = reg_wdata;
      if (reg_wr && reg_addr == 3'd4) clr = '1;
      m_irq  <= (m_stat & ~m_mask) != '0;
      m_stat <= (m_stat & ~clr) | done_pulse;
      if (reg_wr && reg_addr == 3'd0) m_mask <= reg_wdata;
      if (reg_wr && reg_addr == 3'd1) m_mask <= m_mask | reg_wdata;
      if (reg_wr && reg_addr == 3'd2) m_mask <= m_mask & ~reg_wdata;
    end
  end

  function automatic logic [NS-1:0] model_read(input logic [AW-1:0] a);
    case (a)
      3'd0: return m_mask;
      3'd5: return m_stat;
      3'd6: return m_stat & ~m_mask;
      default: return '0;
    endcase
  endfunction

  typedef struct {
    logic [NS-1:0] exp_data;
    logic          exp_irq;
    string         tag;
  } item_t;

  item_t sb[$];
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // Monitor: pops expected items and compares away from the active edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_chk++;
      if (reg_rdata !== it.exp_data || irq !== it.exp_irq) begin
        n_bad++;
        $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                 it.tag, reg_rdata, irq, it.exp_data, it.exp_irq);
      end
    end
  end

  task automatic cyc(input logic wr, input logic [AW-1:0] a,
                     input logic [NS-1:0] d, input logic [NS-1:0] p);
    @(posedge clk); #1;
    reg_wr = wr; reg_addr = a; reg_wdata = d; done_pulse = p;
    @(posedge clk); #1;
    reg_wr = 1'b0; done_pulse = '0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    item_t it;
    reg_addr = a;
    it.exp_data = model_read(a);
    it.exp_irq  = m_irq;
    it.tag      = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    rd(3'd0, "R1 mask after reset");
    rd(3'd5, "R1 status after reset");
    // R2 / R3 / R4: pulses with everything masked
    cyc(1'b0, 3'd0, '0, 16'h0005);
    rd(3'd5, "R2 raw after pulse");
    rd(3'd5, "R3 raw reread");
    rd(3'd6, "R4 masked all disabled");
    cyc(1'b0, 3'd0, '0, '0);
    rd(3'd5, "R2 status held");
    // R7 / R11: unmask bit 0
    cyc(1'b1, 3'd2, 16'h0001, '0);
    rd(3'd6, "R7 masked after clear alias");
    @(posedge clk); #1;
    rd(3'd6, "R11 irq one cycle later");
    // R6: zero data no effect, then set bit 0 back
    cyc(1'b1, 3'd1, 16'h0000, '0);
    rd(3'd0, "R6 zero set no effect");
    cyc(1'b1, 3'd1, 16'h0001, '0);
    @(posedge clk); #1;
    rd(3'd6, "R6 set alias masks again");
    // R5 / R12: load mask, converter group
    cyc(1'b1, 3'd0, 16'h0F0A, '0);
    rd(3'd0, "R5 mask load");
    cyc(1'b0, 3'd0, '0, 16'hF000);
    rd(3'd5, "R12 converter group raw");
    @(posedge clk); #1;
    rd(3'd6, "R12 converter group masked");
    rd(3'd6, "R4 masked reread");
    // R8: zero ack no effect, then ack bit 2 and bit 12
    cyc(1'b1, 3'd3, 16'h0000, '0);
    rd(3'd5, "R8 zero ack no effect");
    cyc(1'b1, 3'd3, 16'h1004, '0);
    rd(3'd5, "R8 ack clears bits");
    // R10: pulse collides with ack on bit 3, and with wipe on bit 7
    cyc(1'b0, 3'd0, '0, 16'h0008);
    cyc(1'b1, 3'd3, 16'h0008, 16'h0008);
    rd(3'd5, "R10 pulse beats ack");
    cyc(1'b1, 3'd4, 16'h0000, 16'h0080);
    rd(3'd5, "R10 pulse beats wipe");
    // R9: wipe with zero data
    cyc(1'b1, 3'd4, 16'h0000, '0);
    rd(3'd5, "R9 wipe clears all");
    @(posedge clk); #1;
    rd(3'd6, "R11 irq drops after wipe");
    // Unused select and writes to read-only views
    cyc(1'b1, 3'd5, 16'hFFFF, 16'h0100);
    rd(3'd7, "R12 unused select reads zero");
    rd(3'd0, "R5 write to view leaves mask");
    repeat (2) @(posedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

endmodule